// File: doc/BRIEF.md
# Gap-Triggered Priority Arbiter with Fairness Window

This block decides which node may drive a shared serial bus next. Up to 63 nodes each present three request lines: a time-critical (isochronous) request, an urgent request and an ordinary asynchronous request. The arbiter never hands out the bus while a packet is in flight. It watches the bus for idle time, and once the bus has been quiet long enough to count as an inter-packet gap it issues exactly one grant. That grant stays on until the granted node reports the end of its packet.

Priority runs from time-critical, through urgent, to ordinary requests. Within a class the lowest-numbered node wins. To stop one node from taking all of the ordinary bandwidth, each node may win ordinary arbitration only once per fairness window. A node that has won is masked from ordinary arbitration until a long idle stretch closes the window. Urgent requests bypass that mask and do not consume a node's ordinary turn.

Top module: `gap_arbiter`

## Requirements
- R1: After a synchronous reset, `grant` is all zeros and `grant_cls` is 0, and every node is again eligible for one ordinary win.
- R2: No new grant is issued while `bus_busy` is high or a grant is held. With the bus quiet and no grant held, the idle count rises by one per clock. A grant is registered on the clock edge that follows the first cycle in which the count has reached GAP_CLKS (default 4). When the bus goes quiet with requests pending, this is the 5th rising edge. Any busy cycle restarts the count.
- R3: `grant` is one-hot or zero. A grant stays unchanged, whatever the requests or `bus_busy` do, until `pkt_done` is seen high while it is held. It is zero from the next edge on. Each gap yields at most one grant.
- R4: When any time-critical request is present at arbitration time, the winner is a time-critical requester.
- R5: With no time-critical request, an urgent request beats every ordinary request. Urgent requests are honoured even from nodes that have used their ordinary turn, and an urgent win does not use up that turn.
- R6: Within the chosen class, the requesting node with the lowest index wins.
- R7: A node that has won ordinary arbitration is ignored for ordinary requests until the fairness window ends. If only such masked nodes request, no grant is issued.
- R8: When FAIR_CLKS (default 16) consecutive idle clocks pass without a grant, the window ends and every node's ordinary turn is restored.
- R9: `grant_cls` reports the class of the held grant: 0 none, 1 time-critical, 2 urgent, 3 ordinary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_busy | input | 1 | High while a packet occupies the bus |
| pkt_done | input | 1 | Granted node marks the end of its packet |
| iso_req | input | NODES | Time-critical request, one bit per node |
| urg_req | input | NODES | Urgent request, one bit per node |
| async_req | input | NODES | Ordinary request, one bit per node |
| grant | output | NODES | One-hot grant, held until end of packet |
| grant_cls | output | 2 | Class of the held grant |

## Verification
The bench drives request patterns of several kinds. Single-class contention separates lowest-index selection from other orders. Mixed-class sets prove that class outranks index. Repeated ordinary requests from the same nodes show the per-window mask and the case where nothing is granted. A long idle stretch followed by the same requests tells a restored turn apart from a still-masked one. An urgent win followed by an ordinary request from the same node shows that urgent wins leave the turn unused. Directed sequences interrupt a gap with a busy cycle to pin the restart of the idle count. They also change requests under a held grant to show that it does not move.

// File: rtl/gap_arb_pkg.sv
package gap_arb_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_ISO  = 2'd1,
        CLS_URG  = 2'd2,
        CLS_ASY  = 2'd3
    } arb_cls_e;

    localparam int NUM_CLASSES = 3;

    typedef struct packed {
        logic open;        // bus quiet long enough to arbitrate
        logic fair_clear;  // fairness window ends this cycle
    } gap_evt_t;

endpackage

// File: rtl/gap_timer.sv
module gap_timer
    import gap_arb_pkg::*;
#(
    parameter int GAP_CLKS  = 4,
    parameter int FAIR_CLKS = 16,
    localparam int CW = $clog2(FAIR_CLKS + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bus_busy,
    input  logic     grant_held,
    input  logic     arb_fire,
    output gap_evt_t evt
);
    logic [CW-1:0] idle_cnt;
    logic          idle;

    assign idle = !bus_busy && !grant_held;

    always_ff @(posedge clk) begin
        if (rst)
            idle_cnt <= '0;
        else if (!idle || arb_fire)
            idle_cnt <= '0;
        else if (idle_cnt != CW'(FAIR_CLKS))
            idle_cnt <= idle_cnt + 1'b1;
    end

    always_comb begin
        evt.open       = idle && (idle_cnt >= CW'(GAP_CLKS));
        evt.fair_clear = idle && !arb_fire && (idle_cnt == CW'(FAIR_CLKS - 1));
    end

    // R2: an open gap always follows a quiet bus cycle
    a_r2_gap_after_quiet: assert property (@(posedge clk) disable iff (rst)
        evt.open |-> $past(!bus_busy));

endmodule

// File: rtl/fair_mask.sv
module fair_mask #(
    parameter int NODES = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fair_clear,
    input  logic [NODES-1:0] set_vec,
    output logic [NODES-1:0] won
);
    always_ff @(posedge clk) begin
        if (rst)
            won <= '0;
        else if (fair_clear)
            won <= '0;
        else
            won <= won | set_vec;
    end

    // R7: an ordinary win never lands on a node that already used its turn
    a_r7_single_turn: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |-> ((set_vec & won) == '0));

endmodule

// File: rtl/class_pick.sv
module class_pick #(
    parameter int NODES = 63
) (
    input  logic [NODES-1:0] req,
    output logic [NODES-1:0] pick,
    output logic             any
);
    assign pick = req & (-req);
    assign any  = |req;
endmodule

// File: rtl/gap_arbiter.sv
module gap_arbiter
    import gap_arb_pkg::*;
#(
    parameter int NODES     = 63,
    parameter int GAP_CLKS  = 4,
    parameter int FAIR_CLKS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_busy,
    input  logic             pkt_done,
    input  logic [NODES-1:0] iso_req,
    input  logic [NODES-1:0] urg_req,
    input  logic [NODES-1:0] async_req,
    output logic [NODES-1:0] grant,
    output logic [1:0]       grant_cls
);
    gap_evt_t         evt;
    logic [NODES-1:0] won;
    logic [NODES-1:0] cls_req  [NUM_CLASSES];
    logic [NODES-1:0] cls_pick [NUM_CLASSES];
    logic             cls_any  [NUM_CLASSES];
    logic [NODES-1:0] sel_vec, set_vec, grant_q;
    arb_cls_e         sel_cls, cls_q;
    logic             arb_fire, grant_held;

    assign cls_req[0] = iso_req;
    assign cls_req[1] = urg_req;
    assign cls_req[2] = async_req & ~won;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        class_pick #(.NODES(NODES)) u_pick (
            .req  (cls_req[c]),
            .pick (cls_pick[c]),
            .any  (cls_any[c])
        );
    end

    always_comb begin
        sel_cls = CLS_NONE;
        sel_vec = '0;
        if (cls_any[0]) begin
            sel_cls = CLS_ISO;
            sel_vec = cls_pick[0];
        end else if (cls_any[1]) begin
            sel_cls = CLS_URG;
            sel_vec = cls_pick[1];
        end else if (cls_any[2]) begin
            sel_cls = CLS_ASY;
            sel_vec = cls_pick[2];
        end
    end

    assign grant_held = |grant_q;
    assign arb_fire   = evt.open && (sel_cls != CLS_NONE);
    assign set_vec    = (arb_fire && sel_cls == CLS_ASY) ? sel_vec : '0;

    gap_timer #(.GAP_CLKS(GAP_CLKS), .FAIR_CLKS(FAIR_CLKS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .bus_busy   (bus_busy),
        .grant_held (grant_held),
        .arb_fire   (arb_fire),
        .evt        (evt)
    );

    fair_mask #(.NODES(NODES)) u_mask (
        .clk        (clk),
        .rst        (rst),
        .fair_clear (evt.fair_clear),
        .set_vec    (set_vec),
        .won        (won)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            cls_q   <= CLS_NONE;
        end else if (grant_held && pkt_done) begin
            grant_q <= '0;
            cls_q   <= CLS_NONE;
        end else if (arb_fire) begin
            grant_q <= sel_vec;
            cls_q   <= sel_cls;
        end
    end

    assign grant     = grant_q;
    assign grant_cls = cls_q;

    // R3: one winner at most
    a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q));

    // R3: a held grant does not move before end of packet
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (grant_q != '0 && !pkt_done) |=> (grant_q == $past(grant_q)));

    // R2: no grant appears out of a busy bus
    a_r2_busy_quiet: assert property (@(posedge clk) disable iff (rst)
        (grant_q == '0 && bus_busy) |=> (grant_q == '0));

    // R4: time-critical requests win an open gap
    a_r4_iso_first: assert property (@(posedge clk) disable iff (rst)
        (grant_q == '0 && evt.open && (|iso_req)) |=> (cls_q == CLS_ISO));

    // R9: class code is zero exactly when nothing is granted
    a_r9_cls_none: assert property (@(posedge clk) disable iff (rst)
        (grant_q == '0) == (cls_q == CLS_NONE));

endmodule

// File: tb/gap_arbiter_bench.sv
module gap_arbiter_bench;

    localparam int N = 8;

    typedef struct packed {
        logic         wait_f;
        logic [N-1:0] iso;
        logic [N-1:0] urg;
        logic [N-1:0] asy;
        logic [N-1:0] gnt;
        logic [1:0]   cls;
    } vec_t;

    // R6 R7 R4 R5 R8 patterns; cls codes per R9
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 8'h00, 8'h06, 8'h02, 2'd3},  // R6 lowest ordinary
        '{1'b0, 8'h00, 8'h00, 8'h06, 8'h04, 2'd3},  // R7 node1 masked
        '{1'b0, 8'h00, 8'h00, 8'h06, 8'h00, 2'd0},  // R7 all masked
        '{1'b0, 8'h80, 8'h01, 8'h08, 8'h80, 2'd1},  // R4 iso over rest
        '{1'b0, 8'h00, 8'h06, 8'h01, 8'h02, 2'd2},  // R5 urgent ignores mask
        '{1'b0, 8'h60, 8'h00, 8'h00, 8'h20, 2'd1},  // R6 lowest iso
        '{1'b0, 8'h00, 8'h00, 8'h09, 8'h01, 2'd3},  // R6 ordinary
        '{1'b1, 8'h00, 8'h00, 8'h02, 8'h02, 2'd3},  // R8 window ended
        '{1'b0, 8'h00, 8'h00, 8'h06, 8'h04, 2'd3},  // R8 node2 restored
        '{1'b0, 8'h00, 8'h00, 8'h06, 8'h00, 2'd0},  // R7 masked again
        '{1'b0, 8'h00, 8'h02, 8'h08, 8'h02, 2'd2},  // R5 urgent over ordinary
        '{1'b0, 8'h00, 8'h10, 8'h00, 8'h10, 2'd2},  // R5 urgent win node4
        '{1'b0, 8'h00, 8'h00, 8'h10, 8'h10, 2'd3}   // R5 turn not used up
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_busy = 1'b1;
    logic         pkt_done = 1'b0;
    logic [N-1:0] iso_req = '0, urg_req = '0, async_req = '0;
    logic [N-1:0] grant;
    logic [1:0]   grant_cls;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    gap_arbiter #(.NODES(N), .GAP_CLKS(4), .FAIR_CLKS(16)) u_gap_arbiter (
        .clk(clk), .rst(rst), .bus_busy(bus_busy), .pkt_done(pkt_done),
        .iso_req(iso_req), .urg_req(urg_req), .async_req(async_req),
        .grant(grant), .grant_cls(grant_cls)
    );

    task automatic check(input string tag, input logic [N-1:0] g_exp, input logic [1:0] c_exp);
        checks++;
        if (grant !== g_exp || grant_cls !== c_exp) begin
            fails++;
            $display("FAIL %s: grant=%h cls=%0d expected grant=%h cls=%0d",
                     tag, grant, grant_cls, g_exp, c_exp);
        end
    endtask

    task automatic finish_pkt(input logic had_grant);
        iso_req = '0; urg_req = '0; async_req = '0;
        bus_busy = 1'b1;
        pkt_done = had_grant;
        @(negedge clk);
        pkt_done = 1'b0;
        check("R3 released after pkt_done", '0, 2'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", '0, 2'd0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wait_f) begin
                bus_busy = 1'b0;
                repeat (20) @(negedge clk);
                iso_req = VECS[i].iso; urg_req = VECS[i].urg; async_req = VECS[i].asy;
                @(negedge clk);
                check($sformatf("R8 row %0d", i), VECS[i].gnt, VECS[i].cls);
            end else begin
                bus_busy = 1'b0;
                iso_req = VECS[i].iso; urg_req = VECS[i].urg; async_req = VECS[i].asy;
                repeat (4) @(negedge clk);
                check($sformatf("R2 row %0d early", i), '0, 2'd0);
                @(negedge clk);
                check($sformatf("R4-R7/R9 row %0d", i), VECS[i].gnt, VECS[i].cls);
            end
            finish_pkt(VECS[i].gnt != '0);
        end

        // R2: a busy bus blocks arbitration
        iso_req = 8'h01;
        bus_busy = 1'b1;
        repeat (10) @(negedge clk);
        check("R2 busy blocks grant", '0, 2'd0);

        // R2: a busy cycle inside the gap restarts the count
        bus_busy = 1'b0;
        repeat (3) @(negedge clk);
        bus_busy = 1'b1;
        @(negedge clk);
        bus_busy = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 restart early", '0, 2'd0);
        @(negedge clk);
        check("R2 restart grant", 8'h01, 2'd1);

        // R3: grant holds while requests and bus change
        iso_req = '1; urg_req = '1; async_req = '1;
        for (int k = 0; k < 6; k++) begin
            bus_busy = k[0];
            @(negedge clk);
        end
        check("R3 hold under changes", 8'h01, 2'd1);
        finish_pkt(1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule